// File: doc/BRIEF.md
# Keypad Scanner and Redial Controller

This block drives a 4x4 telephone key matrix one row at a time, reads four active-low column lines, filters each key press over a millisecond time base and turns accepted keys into actions. Twelve keys are dial digits. The fourth column holds four control keys: pause, mute, flash and redial. The dial digits go out as a stream of 4-bit codes to a downstream dialer, which can hold the stream back with a busy input.

The row pins have a second use. While the phone is on-hook the row drivers are released. At the moment the filtered hook input shows off-hook, the levels on the rows are captured once as four mode straps for the dialer. The block also keeps the last manually dialed number in a 32-entry store and sends it out again on a redial request. It controls a microphone-mute flag, a timed pause and a one-cycle flash request. All timing counts pulses on a 1 ms tick-enable input.

Top module: `kpd_dialer_ctrl`

## Requirements
- R1: While off-hook, `row_oe_o` is 1 and exactly one bit of `row_o` is low. The low bit moves from row 0 up to row 3 and wraps, advancing one row per clock.
- R2: While on-hook, `row_oe_o` is 0. In the cycle the filtered hook state becomes off-hook, `row_i` is captured into `straps_o`, and the value is held for the rest of the call. Bit 0 selects tone (0) or pulse (1) dialing. Bit 1 selects 10 (0) or 20 (1) pulses per second. Bit 2 selects a 40/60 (0) or 33/67 (1) make/break ratio. Bit 3 selects 82/82 ms (0) or 82/160 ms (1) tone timing.
- R3: `off_hook_o` goes to 1 only after `hook_i` has been high for 15 ticks in a row. It goes to 0 only after `hook_i` has been low for 240 ticks in a row. Shorter excursions have no effect.
- R4: A key is accepted only after its scan pattern has been unchanged for 64 ticks. A pattern with more than one key down counts as no key. Key (row r, column c) with r,c in 0..3 maps as follows. Rows 0 to 2, columns 0 to 2, give digit 3r+c+1. Row 3 gives `*` (code 10), 0 (code 0) and `#` (code 11) for columns 0 to 2. Column 3 gives pause, mute, flash and redial for rows 0 to 3.
- R5: After a key is accepted, no other key is accepted until the matrix has been stably empty for 64 ticks. A key that becomes stable while `busy_i` is high is dropped.
- R6: An accepted digit key gives one cycle of `digit_valid_o` with its code on `digit_o`. The first such digit in a call clears the redial store. The first 32 digits of a call are stored; later digits are dialed but not stored.
- R7: Redial, when the store is not empty, sends the stored digits in dialed order, one per clock while `busy_i` is low. Keys are ignored while the replay runs. Redial with an empty store does nothing. The stored number survives on-hook and can be replayed in each later call.
- R8: Pause holds `mute_o` high for 2200 ticks. During that time no digit is sent and keys are ignored.
- R9: Each accepted mute key toggles the mute flag, which `mute_o` shows. The flag is cleared when the phone goes on-hook.
- R10: An accepted flash key gives a one-cycle pulse on `flash_o` and no digit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle enable every millisecond |
| hook_i | input | 1 | Raw hook switch, 1 = off-hook |
| busy_i | input | 1 | Downstream dialer busy |
| row_i | input | 4 | Level read back from the row pins |
| col_i | input | 4 | Column inputs, low = connected to the driven row |
| row_o | output | 4 | Row drive, active low |
| row_oe_o | output | 1 | Row driver enable |
| straps_o | output | 4 | Mode straps captured at off-hook |
| off_hook_o | output | 1 | Filtered hook state |
| digit_valid_o | output | 1 | Digit strobe |
| digit_o | output | 4 | Digit code |
| mute_o | output | 1 | Microphone inhibit |
| flash_o | output | 1 | Flash request pulse |

## Verification
Every key of the matrix is pressed once, so a wrong row or column in the code map shows up as a wrong digit. Patterns that must produce nothing are tried next: a press shorter than the filter window, two keys held together, a press while busy, and a slide from one key to another without release. These separate a correct acceptance rule from a weaker one. The hook line is driven with excursions just under and just over both filter lengths. Redial is tried with an empty store, with a three-digit number across two calls, with a refilled number, and with a 33-digit call that must replay only 32 digits. Strap capture is checked with two different row patterns in separate calls.

// File: rtl/kpd_pkg.sv
package kpd_pkg;
  typedef logic [3:0] digit_t;
  localparam digit_t DIG_STAR = 4'd10;
  localparam digit_t DIG_HASH = 4'd11;

  // function keys, indexed by row in column 3
  typedef enum logic [1:0] {FN_PAUSE, FN_MUTE, FN_FLASH, FN_REDIAL} fn_e;

  function automatic digit_t key_digit(logic [1:0] r, logic [1:0] c);
    if (r == 2'd3) begin
      case (c)
        2'd0:    return DIG_STAR;
        2'd1:    return 4'd0;
        default: return DIG_HASH;
      endcase
    end
    return 4'(r) * 4'd3 + 4'(c) + 4'd1;
  endfunction
endpackage

// File: rtl/kpd_hook_filter.sv
module kpd_hook_filter #(
  parameter int unsigned ON_TICKS  = 15,
  parameter int unsigned OFF_TICKS = 240
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic hook_i,
  output logic off_hook_o
);
  localparam int unsigned MAXT = (ON_TICKS > OFF_TICKS) ? ON_TICKS : OFF_TICKS;
  localparam int unsigned CW = $clog2(MAXT + 1);
  localparam logic [CW-1:0] ON_LIM  = CW'(ON_TICKS - 1);
  localparam logic [CW-1:0] OFF_LIM = CW'(OFF_TICKS - 1);

  logic          state_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;

  assign lim = state_q ? OFF_LIM : ON_LIM;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= 1'b0;
      cnt_q   <= '0;
    end else if (hook_i == state_q) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      if (cnt_q == lim) begin
        state_q <= hook_i;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign off_hook_o = state_q;

  AST_HOOK_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(state_q)); // R3
  AST_HOOK_FOLLOWS_RAW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hook_i == state_q) |=> $stable(state_q)); // R3
endmodule

// File: rtl/kpd_scan.sv
module kpd_scan #(
  parameter int unsigned DB_TICKS = 64
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       tick_i,
  input  logic [3:0] col_i,
  output logic [3:0] row_o,
  output logic       key_evt_o,
  output logic [3:0] key_idx_o
);
  localparam int unsigned CW = $clog2(DB_TICKS + 1);
  localparam logic [CW-1:0] DB_L = CW'(DB_TICKS);

  logic [1:0]    row_sel_q;
  logic [11:0]   hits_q;
  logic [15:0]   snap_q;
  logic          raw_v;
  logic [3:0]    raw_idx;
  logic          cand_v_q, stab_v_q, evt_q;
  logic [3:0]    cand_idx_q, stab_idx_q;
  logic [CW-1:0] cnt_q;
  logic          same;

  assign row_o = en_i ? ~(4'b0001 << row_sel_q) : 4'hF;

  // one full frame of column samples per four clocks
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_sel_q <= '0;
      hits_q    <= '0;
      snap_q    <= '0;
    end else if (!en_i) begin
      row_sel_q <= '0;
      hits_q    <= '0;
      snap_q    <= '0;
    end else begin
      row_sel_q <= row_sel_q + 1'b1;
      case (row_sel_q)
        2'd0:    hits_q[3:0]  <= ~col_i;
        2'd1:    hits_q[7:4]  <= ~col_i;
        2'd2:    hits_q[11:8] <= ~col_i;
        default: snap_q       <= {~col_i, hits_q};
      endcase
    end
  end

  always_comb begin
    raw_v   = ($countones(snap_q) == 1);
    raw_idx = '0;
    if (raw_v) begin
      for (int i = 0; i < 16; i++) begin
        if (snap_q[i]) raw_idx = 4'(i);
      end
    end
  end

  assign same = ({raw_v, raw_idx} == {cand_v_q, cand_idx_q});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cand_v_q <= 1'b0; cand_idx_q <= '0; cnt_q <= '0;
      stab_v_q <= 1'b0; stab_idx_q <= '0; evt_q <= 1'b0;
    end else if (!en_i) begin
      cand_v_q <= 1'b0; cand_idx_q <= '0; cnt_q <= '0;
      stab_v_q <= 1'b0; stab_idx_q <= '0; evt_q <= 1'b0;
    end else begin
      evt_q <= 1'b0;
      if (!same) begin
        cand_v_q   <= raw_v;
        cand_idx_q <= raw_idx;
        cnt_q      <= '0;
      end else if (cnt_q == DB_L) begin
        stab_v_q   <= cand_v_q;
        stab_idx_q <= cand_idx_q;
        evt_q      <= cand_v_q && !stab_v_q;
      end else if (tick_i) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign key_evt_o = evt_q;
  assign key_idx_o = stab_idx_q;

  AST_ROW_ROTATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i)) |-> (row_o == {$past(row_o[2:0]), $past(row_o[3])})); // R1
  AST_EVT_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_evt_o |=> !key_evt_o); // R5
  AST_EVT_FROM_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_evt_o |-> !$past(stab_v_q)); // R5
endmodule

// File: rtl/kpd_redial_mem.sv
module kpd_redial_mem #(
  parameter int unsigned DEPTH = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic       clr_i,
  input  logic [3:0] wdata_i,
  input  logic       start_i,
  input  logic       step_i,
  input  logic       abort_i,
  output logic [3:0] rdata_o,
  output logic       active_o
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned LW = $clog2(DEPTH + 1);
  localparam logic [LW-1:0] DEPTH_L = LW'(DEPTH);

  logic [3:0]    mem_q [DEPTH];
  logic [LW-1:0] len_q;
  logic [AW-1:0] rd_ptr_q;
  logic          active_q;
  logic          we;
  logic [AW-1:0] waddr;

  assign we    = wr_i && (clr_i || len_q < DEPTH_L);
  assign waddr = clr_i ? '0 : AW'(len_q);

  always_ff @(posedge clk_i) begin
    if (we) mem_q[waddr] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q    <= '0;
      rd_ptr_q <= '0;
      active_q <= 1'b0;
    end else begin
      if (we) len_q <= clr_i ? LW'(1) : len_q + 1'b1;
      if (abort_i) begin
        active_q <= 1'b0;
      end else if (!active_q) begin
        if (start_i && len_q != '0) begin
          active_q <= 1'b1;
          rd_ptr_q <= '0;
        end
      end else if (step_i) begin
        if (LW'(rd_ptr_q) + 1'b1 == len_q) active_q <= 1'b0;
        else rd_ptr_q <= rd_ptr_q + 1'b1;
      end
    end
  end

  assign rdata_o  = mem_q[rd_ptr_q];
  assign active_o = active_q;

  AST_LEN_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_q <= DEPTH_L); // R6
  AST_PTR_IN_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> (LW'(rd_ptr_q) < len_q)); // R7
  AST_NO_WRITE_IN_REPLAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> !wr_i); // R7
endmodule

// File: rtl/kpd_dialer_ctrl.sv
module kpd_dialer_ctrl #(
  parameter int unsigned HOOK_ON_TICKS  = 15,
  parameter int unsigned HOOK_OFF_TICKS = 240,
  parameter int unsigned KEY_DB_TICKS   = 64,
  parameter int unsigned PAUSE_TICKS    = 2200,
  parameter int unsigned REDIAL_DEPTH   = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       hook_i,
  input  logic       busy_i,
  input  logic [3:0] row_i,
  input  logic [3:0] col_i,
  output logic [3:0] row_o,
  output logic       row_oe_o,
  output logic [3:0] straps_o,
  output logic       off_hook_o,
  output logic       digit_valid_o,
  output logic [3:0] digit_o,
  output logic       mute_o,
  output logic       flash_o
);
  import kpd_pkg::*;

  localparam int unsigned PW = $clog2(PAUSE_TICKS + 1);
  localparam logic [PW-1:0] PAUSE_L = PW'(PAUSE_TICKS);

  logic          off_hook, scan_en_q;
  logic          key_evt;
  logic [3:0]    key_idx;
  logic [1:0]    krow, kcol;
  logic          accept, dig_key, is_fn;
  fn_e           fn;
  logic          rep_active, step;
  digit_t        rep_digit;
  logic          fresh_q, mute_q, flash_q, dv_q;
  digit_t        digit_q;
  logic [3:0]    straps_q;
  logic [PW-1:0] pause_q;
  logic          pause_act;

  kpd_hook_filter #(.ON_TICKS(HOOK_ON_TICKS), .OFF_TICKS(HOOK_OFF_TICKS)) u_hook (
    .clk_i, .rst_ni, .tick_i, .hook_i, .off_hook_o(off_hook)
  );

  kpd_scan #(.DB_TICKS(KEY_DB_TICKS)) u_scan (
    .clk_i, .rst_ni, .en_i(scan_en_q), .tick_i, .col_i,
    .row_o, .key_evt_o(key_evt), .key_idx_o(key_idx)
  );

  assign krow      = key_idx[3:2];
  assign kcol      = key_idx[1:0];
  assign is_fn     = (kcol == 2'd3);
  assign fn        = fn_e'(krow);
  assign pause_act = (pause_q != '0);
  assign accept    = key_evt && !busy_i && !pause_act && !rep_active && off_hook;
  assign dig_key   = accept && !is_fn;
  assign step      = rep_active && !busy_i && !pause_act && off_hook;

  kpd_redial_mem #(.DEPTH(REDIAL_DEPTH)) u_mem (
    .clk_i, .rst_ni,
    .wr_i(dig_key), .clr_i(fresh_q), .wdata_i(key_digit(krow, kcol)),
    .start_i(accept && is_fn && fn == FN_REDIAL), .step_i(step),
    .abort_i(!off_hook), .rdata_o(rep_digit), .active_o(rep_active)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scan_en_q <= 1'b0;
      straps_q  <= '0;
      fresh_q   <= 1'b1;
      mute_q    <= 1'b0;
      flash_q   <= 1'b0;
      dv_q      <= 1'b0;
      digit_q   <= '0;
      pause_q   <= '0;
    end else begin
      scan_en_q <= off_hook;
      // rows are still released in the first off-hook cycle
      if (off_hook && !scan_en_q) straps_q <= row_i;
      dv_q    <= dig_key || step;
      digit_q <= dig_key ? key_digit(krow, kcol) : rep_digit;
      flash_q <= accept && is_fn && fn == FN_FLASH;
      if (!off_hook) begin
        fresh_q <= 1'b1;
        mute_q  <= 1'b0;
        pause_q <= '0;
      end else begin
        if (dig_key) fresh_q <= 1'b0;
        if (accept && is_fn && fn == FN_MUTE) mute_q <= ~mute_q;
        if (accept && is_fn && fn == FN_PAUSE) pause_q <= PAUSE_L;
        else if (tick_i && pause_act) pause_q <= pause_q - 1'b1;
      end
    end
  end

  assign row_oe_o      = scan_en_q;
  assign straps_o      = straps_q;
  assign off_hook_o    = off_hook;
  assign digit_valid_o = dv_q;
  assign digit_o       = digit_q;
  assign mute_o        = mute_q | pause_act;
  assign flash_o       = flash_q;

  AST_ROWS_FLOAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !off_hook_o |=> !row_oe_o); // R2
  AST_STRAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_oe_o && $past(row_oe_o)) |-> $stable(straps_o)); // R2
  AST_NO_DIGIT_IN_PAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_act |-> !digit_valid_o); // R8
  AST_MUTE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (off_hook && !accept) |=> $stable(mute_q)); // R9
  AST_FLASH_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flash_o |=> !flash_o); // R10
  AST_FLASH_NO_DIGIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flash_o |-> !digit_valid_o); // R10
endmodule

// File: tb/tb_kpd_dialer_ctrl.sv
module tb_kpd_dialer_ctrl;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       hook_i = 1'b0;
  logic       busy_i = 1'b0;
  logic [3:0] row_i, col_i, row_o, straps_o, digit_o;
  logic       row_oe_o, off_hook_o, digit_valid_o, mute_o, flash_o;
  logic [3:0] strap_pull = 4'h0;
  logic [15:0] key_down = '0;

  int n_chk = 0;
  int n_err = 0;
  int dq[$];
  int nflash = 0;

  always #5 clk = ~clk;

  kpd_dialer_ctrl dut (
    .clk_i(clk), .rst_ni, .tick_i, .hook_i, .busy_i, .row_i, .col_i,
    .row_o, .row_oe_o, .straps_o, .off_hook_o, .digit_valid_o, .digit_o,
    .mute_o, .flash_o
  );

  assign row_i = row_oe_o ? row_o : strap_pull;

  always_comb begin
    col_i = 4'hF;
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++)
        if (key_down[r*4+c] && row_oe_o && !row_o[r]) col_i[c] = 1'b0;
  end

  always @(negedge clk) begin
    if (digit_valid_o) dq.push_back(int'(digit_o));
    if (flash_o) nflash++;
  end

  initial begin
    int tc = 0;
    forever begin
      @(negedge clk);
      tc = (tc + 1) % 4;
      tick_i = (tc == 0);
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_q(input string req, input int e[$]);
    check({req, " count"}, dq.size(), e.size());
    for (int i = 0; i < e.size() && i < dq.size(); i++)
      check({req, " digit"}, dq[i], e[i]);
    dq.delete();
  endtask

  task automatic wait_ticks(input int n);
    repeat (n * 4) @(negedge clk);
  endtask

  function automatic int didx(input int d);
    if (d == 0) return 13;
    if (d == 10) return 12;
    if (d == 11) return 14;
    return ((d - 1) / 3) * 4 + (d - 1) % 3;
  endfunction

  task automatic press(input int idx, input int hold = 80);
    key_down = 16'(1) << idx;
    wait_ticks(hold);
    key_down = '0;
    wait_ticks(80);
  endtask

  task automatic off_hook(input logic [3:0] pull);
    strap_pull = pull;
    hook_i = 1'b1;
    wait_ticks(20);
  endtask

  task automatic on_hook();
    hook_i = 1'b0;
    wait_ticks(260);
  endtask

  task automatic t_reset();
    check("R2 reset row_oe", row_oe_o, 0);
    check("R3 reset off_hook", off_hook_o, 0);
    check("R6 reset digit_valid", digit_valid_o, 0);
    check("R9 reset mute", mute_o, 0);
    check("R10 reset flash", flash_o, 0);
  endtask

  task automatic t_hook();
    hook_i = 1'b1; wait_ticks(10);
    check("R3 short off-hook glitch", off_hook_o, 0);
    hook_i = 1'b0; wait_ticks(20);
    check("R3 after glitch", off_hook_o, 0);
    check("R2 rows released on-hook", row_oe_o, 0);
    off_hook(4'b1010);
    check("R3 off-hook after 15", off_hook_o, 1);
    check("R2 straps captured", straps_o, 4'b1010);
    hook_i = 1'b0; wait_ticks(200);
    check("R3 on-hook not before 240", off_hook_o, 1);
    hook_i = 1'b1; wait_ticks(5);
    check("R2 straps held in call", straps_o, 4'b1010);
    on_hook();
    check("R3 on-hook after 240", off_hook_o, 0);
    off_hook(4'b0101);
    check("R2 straps new call", straps_o, 4'b0101);
  endtask

  task automatic t_rows();
    logic [3:0] prev;
    check("R1 row_oe in call", row_oe_o, 1);
    prev = row_o;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R1 one row low", $countones(~row_o), 1);
      check("R1 row order", row_o, {prev[2:0], prev[3]});
      prev = row_o;
    end
  endtask

  task automatic t_digits();
    int e[$];
    dq.delete();
    press(15);
    check("R7 redial with empty store", dq.size(), 0);
    for (int d = 1; d <= 9; d++) press(didx(d));
    press(12); press(13); press(14);
    e = {1, 2, 3, 4, 5, 6, 7, 8, 9, 10, 0, 11};
    check_q("R4 R6 full keypad", e);
  endtask

  task automatic t_ignore();
    int e[$];
    dq.delete();
    press(didx(5), 40);
    check("R4 short press ignored", dq.size(), 0);
    key_down = (16'(1) << didx(1)) | (16'(1) << didx(6));
    wait_ticks(80); key_down = '0; wait_ticks(80);
    check("R4 two keys ignored", dq.size(), 0);
    busy_i = 1'b1; press(didx(5)); busy_i = 1'b0;
    check("R5 busy drops key", dq.size(), 0);
    key_down = 16'(1) << didx(7); wait_ticks(80);
    key_down = 16'(1) << didx(8); wait_ticks(80);
    key_down = '0; wait_ticks(80);
    e = {7};
    check_q("R5 slide without release", e);
  endtask

  task automatic t_mute_flash();
    press(7);
    check("R9 mute on", mute_o, 1);
    press(7);
    check("R9 mute off", mute_o, 0);
    press(7);
    check("R9 mute on again", mute_o, 1);
    on_hook();
    check("R9 mute cleared on-hook", mute_o, 0);
    off_hook(4'h0);
    nflash = 0; dq.delete();
    press(11);
    check("R10 one flash pulse", nflash, 1);
    check("R10 flash gives no digit", dq.size(), 0);
  endtask

  task automatic t_pause();
    int e[$];
    dq.delete();
    press(3);
    check("R8 mute held in pause", mute_o, 1);
    press(didx(4));
    check("R8 key ignored in pause", dq.size(), 0);
    check("R8 still muted", mute_o, 1);
    wait_ticks(2000);
    check("R8 pause ended", mute_o, 0);
    press(didx(4));
    e = {4};
    check_q("R8 dial after pause", e);
  endtask

  task automatic t_redial();
    int e[$];
    on_hook(); off_hook(4'h0);
    press(didx(5)); press(didx(1)); press(didx(2));
    e = {5, 1, 2};
    check_q("R6 manual number", e);
    on_hook(); off_hook(4'h0);
    press(15);
    check_q("R7 redial next call", e);
    press(15);
    check_q("R7 redial repeated", e);
    on_hook(); off_hook(4'h0);
    press(didx(9));
    e = {9};
    check_q("R6 first digit dialed", e);
    on_hook(); off_hook(4'h0);
    press(15);
    check_q("R6 store refilled", e);
  endtask

  task automatic t_overflow();
    int e[$];
    on_hook(); off_hook(4'h0);
    dq.delete();
    for (int i = 0; i < 33; i++) press(didx(i % 10));
    check("R6 33rd digit still dialed", dq.size(), 33);
    dq.delete();
    on_hook(); off_hook(4'h0);
    press(15);
    for (int i = 0; i < 32; i++) e.push_back(i % 10);
    check_q("R6 R7 replay keeps 32", e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired R1 actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    t_hook();
    t_rows();
    t_digits();
    t_ignore();
    t_mute_flash();
    t_pause();
    t_redial();
    t_overflow();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule